// File: doc/BRIEF.md
# Selective Transmitter Blocking Controller

This controller sits beside the execution stage of an out-of-order core and decides, for each functional unit and each cycle, whether the instruction that unit is about to execute may proceed. Each unit reports a valid flag, its opcode, its reorder-buffer index and whether any of its operands carries speculative taint. The controller compares the opcode against a small programmable table of transmitter patterns. A transmitter is an instruction class that could form a timing side channel. The controller raises an inhibit to that unit only while a valid, tainted transmitter is present.

Blocking is local. A unit that is not inhibited keeps running, so other units and untainted work never stall. The decision is purely combinational from the unit's inputs, so an instruction that is not blocked pays no extra cycle. The inhibit also falls in the same cycle that the taint reads as cleared.

A pipeline flush names a circular, inclusive range of reorder-buffer indices. When a held instruction's index lies in that range, its inhibit drops at once. It then stays down for as long as the unit keeps presenting that same squashed instruction.

Top module: `xmit_block_ctrl`

## Requirements
- R1: After reset every table entry is disabled, so no unit is inhibited whatever its opcode or taint until an entry is written.
- R2: Table entry k hits an opcode when the entry is enabled and ((opcode XOR match_k) AND mask_k) is zero; a mask bit of 1 means that bit is compared. An opcode is a transmitter when any entry hits it.
- R3: A unit's inhibit is 1 in the same cycle in which that unit has valid=1, taint=1 and a transmitter opcode, unless a flush covers it (R7).
- R4: A unit presenting an untainted instruction, or a non-transmitter opcode, has inhibit 0 in that same cycle.
- R5: A held unit's inhibit falls to 0 in the first cycle in which its taint input reads 0.
- R6: Each unit's inhibit depends only on that unit's inputs; a blocked unit never inhibits another unit.
- R7: A flush with range start S and end E covers index I when ((I-S) mod 2^W) <= ((E-S) mod 2^W), W being the index width. A covered valid unit has inhibit 0 in the flush cycle. It keeps inhibit 0 in later cycles while it stays valid with the same index. Dropping valid or presenting a new index ends this.
- R8: A flush whose range does not cover a unit's index has no effect on that unit's inhibit.
- R9: A table write (enable, index, match, mask, entry-enable bit) takes effect from the cycle after the write edge; a write with the entry-enable bit 0 removes that entry from matching.
- R10: A unit with valid=0 has inhibit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | ENT_IDX_W | Table entry to write |
| cfg_en | input | 1 | Entry enable bit written |
| cfg_match | input | OPC_W | Opcode match pattern written |
| cfg_mask | input | OPC_W | Compare mask written (1 = compare bit) |
| fu_valid | input | NUM_FU | Per-unit instruction valid |
| fu_opcode | input | NUM_FU*OPC_W | Per-unit opcode, unit u at bits [u*OPC_W +: OPC_W] |
| fu_rob_idx | input | NUM_FU*ROB_W | Per-unit reorder-buffer index, unit u at [u*ROB_W +: ROB_W] |
| fu_taint | input | NUM_FU | Per-unit operand taint |
| flush_valid | input | 1 | Flush strobe |
| flush_start | input | ROB_W | First index of the flushed range |
| flush_end | input | ROB_W | Last index of the flushed range (inclusive) |
| fu_inhibit | output | NUM_FU | Per-unit hold request |

## Verification
The bench builds the controller with three functional units, four table entries and a 4-bit reorder-buffer index. With three units, one unit can be blocked while a second holds a tainted non-transmitter and a third an untainted transmitter, all in the same cycle. The 4-bit index makes the flush range wrap past index 15 with only a few values, so both a wrapping hit and a wrapping miss can be exercised. Four entries leave room for an exact-match pattern and a masked group pattern side by side, with one entry later disabled again.

// File: rtl/xmit_block_pkg.sv
package xmit_block_pkg;

  typedef enum logic [1:0] {
    GS_PASS   = 2'd0,
    GS_HOLD   = 2'd1,
    GS_KILLED = 2'd2
  } gate_state_e;

  localparam int unsigned DEF_NUM_FU      = 3;
  localparam int unsigned DEF_OPC_W       = 7;
  localparam int unsigned DEF_ROB_W       = 5;
  localparam int unsigned DEF_NUM_ENTRIES = 8;

endpackage

// File: rtl/xmit_cfg_table.sv
module xmit_cfg_table #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned OPC_W       = 7,
  parameter int unsigned ENT_IDX_W   = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [ENT_IDX_W-1:0]         cfg_idx,
  input  logic                         cfg_en,
  input  logic [OPC_W-1:0]             cfg_match,
  input  logic [OPC_W-1:0]             cfg_mask,
  output logic [NUM_ENTRIES-1:0]       ent_en,
  output logic [NUM_ENTRIES*OPC_W-1:0] ent_match,
  output logic [NUM_ENTRIES*OPC_W-1:0] ent_mask
);

  logic [NUM_ENTRIES-1:0]       en_q, en_d;
  logic [NUM_ENTRIES*OPC_W-1:0] match_q, match_d;
  logic [NUM_ENTRIES*OPC_W-1:0] mask_q, mask_d;
  logic [NUM_ENTRIES-1:0]       wr_sel;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_sel
    assign wr_sel[k] = cfg_we && (cfg_idx == ENT_IDX_W'(k));
  end

  always_comb begin
    en_d    = en_q;
    match_d = match_q;
    mask_d  = mask_q;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (wr_sel[k]) begin
        en_d[k]                  = cfg_en;
        match_d[k*OPC_W +: OPC_W] = cfg_match;
        mask_d[k*OPC_W +: OPC_W]  = cfg_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      match_q <= '0;
      mask_q  <= '0;
    end else if (cfg_we) begin
      en_q    <= en_d;
      match_q <= match_d;
      mask_q  <= mask_d;
    end
  end

  assign ent_en    = en_q;
  assign ent_match = match_q;
  assign ent_mask  = mask_q;

endmodule

// File: rtl/xmit_opc_match.sv
module xmit_opc_match #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned OPC_W       = 7
) (
  input  logic [OPC_W-1:0]             opcode,
  input  logic [NUM_ENTRIES-1:0]       ent_en,
  input  logic [NUM_ENTRIES*OPC_W-1:0] ent_match,
  input  logic [NUM_ENTRIES*OPC_W-1:0] ent_mask,
  output logic                         is_xmit
);

  logic [NUM_ENTRIES-1:0] hit;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    logic [OPC_W-1:0] diff;
    assign diff   = (opcode ^ ent_match[k*OPC_W +: OPC_W]) & ent_mask[k*OPC_W +: OPC_W];
    assign hit[k] = ent_en[k] && (diff == '0);
  end

  assign is_xmit = |hit;

endmodule

// File: rtl/xmit_fu_gate.sv
module xmit_fu_gate
  import xmit_block_pkg::*;
#(
  parameter int unsigned ROB_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [ROB_W-1:0] rob_idx,
  input  logic             taint,
  input  logic             is_xmit,
  input  logic             flush_valid,
  input  logic [ROB_W-1:0] flush_start,
  input  logic [ROB_W-1:0] flush_end,
  output logic             inhibit
);

  gate_state_e      state_q, state_d;
  logic [ROB_W-1:0] kill_idx_q, kill_idx_d;
  logic [ROB_W-1:0] off, span;
  logic             covered_now, killed_now, want;

  assign off         = rob_idx - flush_start;
  assign span        = flush_end - flush_start;
  assign covered_now = flush_valid && valid && (off <= span);
  assign killed_now  = (state_q == GS_KILLED) && valid && (rob_idx == kill_idx_q);
  assign want        = valid && taint && is_xmit;
  assign inhibit     = want && !covered_now && !killed_now;

  always_comb begin
    state_d    = state_q;
    kill_idx_d = kill_idx_q;
    if (covered_now) begin
      state_d    = GS_KILLED;
      kill_idx_d = rob_idx;
    end else if (killed_now) begin
      state_d = GS_KILLED;
    end else if (want) begin
      state_d = GS_HOLD;
    end else begin
      state_d = GS_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= GS_PASS;
      kill_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      kill_idx_q <= kill_idx_d;
    end
  end

endmodule

// File: rtl/xmit_block_ctrl.sv
module xmit_block_ctrl
  import xmit_block_pkg::*;
#(
  parameter int unsigned NUM_FU      = DEF_NUM_FU,
  parameter int unsigned OPC_W       = DEF_OPC_W,
  parameter int unsigned ROB_W       = DEF_ROB_W,
  parameter int unsigned NUM_ENTRIES = DEF_NUM_ENTRIES,
  parameter int unsigned ENT_IDX_W   = $clog2(NUM_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ENT_IDX_W-1:0]    cfg_idx,
  input  logic                    cfg_en,
  input  logic [OPC_W-1:0]        cfg_match,
  input  logic [OPC_W-1:0]        cfg_mask,
  input  logic [NUM_FU-1:0]       fu_valid,
  input  logic [NUM_FU*OPC_W-1:0] fu_opcode,
  input  logic [NUM_FU*ROB_W-1:0] fu_rob_idx,
  input  logic [NUM_FU-1:0]       fu_taint,
  input  logic                    flush_valid,
  input  logic [ROB_W-1:0]        flush_start,
  input  logic [ROB_W-1:0]        flush_end,
  output logic [NUM_FU-1:0]       fu_inhibit
);

  logic [NUM_ENTRIES-1:0]       ent_en;
  logic [NUM_ENTRIES*OPC_W-1:0] ent_match;
  logic [NUM_ENTRIES*OPC_W-1:0] ent_mask;

  xmit_cfg_table #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .OPC_W      (OPC_W),
    .ENT_IDX_W  (ENT_IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_en   (cfg_en),
    .cfg_match(cfg_match),
    .cfg_mask (cfg_mask),
    .ent_en   (ent_en),
    .ent_match(ent_match),
    .ent_mask (ent_mask)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    logic is_xmit;

    xmit_opc_match #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .OPC_W      (OPC_W)
    ) u_match (
      .opcode   (fu_opcode[u*OPC_W +: OPC_W]),
      .ent_en   (ent_en),
      .ent_match(ent_match),
      .ent_mask (ent_mask),
      .is_xmit  (is_xmit)
    );

    xmit_fu_gate #(
      .ROB_W(ROB_W)
    ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (fu_valid[u]),
      .rob_idx    (fu_rob_idx[u*ROB_W +: ROB_W]),
      .taint      (fu_taint[u]),
      .is_xmit    (is_xmit),
      .flush_valid(flush_valid),
      .flush_start(flush_start),
      .flush_end  (flush_end),
      .inhibit    (fu_inhibit[u])
    );
  end

endmodule

// File: rtl/xmit_block_chk.sv
module xmit_block_chk #(
  parameter int unsigned NUM_FU = 3,
  parameter int unsigned OPC_W  = 7,
  parameter int unsigned ROB_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [NUM_FU-1:0]       fu_valid,
  input logic [NUM_FU*OPC_W-1:0] fu_opcode,
  input logic [NUM_FU*ROB_W-1:0] fu_rob_idx,
  input logic [NUM_FU-1:0]       fu_taint,
  input logic                    flush_valid,
  input logic [ROB_W-1:0]        flush_start,
  input logic [ROB_W-1:0]        flush_end,
  input logic [NUM_FU-1:0]       fu_inhibit
);

  for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
    logic [ROB_W-1:0] idx;
    logic [OPC_W-1:0] opc;
    logic             in_range;
    assign idx      = fu_rob_idx[u*ROB_W +: ROB_W];
    assign opc      = fu_opcode[u*OPC_W +: OPC_W];
    assign in_range = ROB_W'(idx - flush_start) <= ROB_W'(flush_end - flush_start);

    // R3 R4 R5: an inhibit only ever accompanies a valid, tainted instruction
    a_r4_inhibit_needs_taint: assert property (@(posedge clk) disable iff (!rst_n)
      fu_inhibit[u] |-> fu_taint[u]);

    // R10
    a_r10_invalid_free: assert property (@(posedge clk) disable iff (!rst_n)
      !fu_valid[u] |-> !fu_inhibit[u]);

    // R7: a squashed instruction stays released while it lingers
    a_r7_flush_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && fu_valid[u] && in_range) |=>
        (!(fu_valid[u] && idx == $past(idx)) || !fu_inhibit[u]));

    // R9: with no table write and no flush, stable inputs give a stable inhibit
    a_r9_stable_decision: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && !$past(flush_valid) && !flush_valid &&
       $stable(fu_valid[u]) && $stable(fu_taint[u]) && $stable(opc) && $stable(idx))
        |-> $stable(fu_inhibit[u]));
  end

endmodule

bind xmit_block_ctrl xmit_block_chk #(
  .NUM_FU(NUM_FU),
  .OPC_W (OPC_W),
  .ROB_W (ROB_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .fu_valid   (fu_valid),
  .fu_opcode  (fu_opcode),
  .fu_rob_idx (fu_rob_idx),
  .fu_taint   (fu_taint),
  .flush_valid(flush_valid),
  .flush_start(flush_start),
  .flush_end  (flush_end),
  .fu_inhibit (fu_inhibit)
);

// File: tb/sim_xmit_block_ctrl.sv
`timescale 1ns/1ps
module sim_xmit_block_ctrl;

  localparam int unsigned NUM_FU      = 3;
  localparam int unsigned OPC_W       = 7;
  localparam int unsigned ROB_W       = 4;
  localparam int unsigned NUM_ENTRIES = 4;
  localparam int unsigned ENT_IDX_W   = 2;

  logic                    clk;
  logic                    rst_n;
  logic                    cfg_we;
  logic [ENT_IDX_W-1:0]    cfg_idx;
  logic                    cfg_en;
  logic [OPC_W-1:0]        cfg_match;
  logic [OPC_W-1:0]        cfg_mask;
  logic [NUM_FU-1:0]       fu_valid;
  logic [NUM_FU*OPC_W-1:0] fu_opcode;
  logic [NUM_FU*ROB_W-1:0] fu_rob_idx;
  logic [NUM_FU-1:0]       fu_taint;
  logic                    flush_valid;
  logic [ROB_W-1:0]        flush_start;
  logic [ROB_W-1:0]        flush_end;
  logic [NUM_FU-1:0]       fu_inhibit;

  int n_checks;
  int n_fail;

  xmit_block_ctrl #(
    .NUM_FU(NUM_FU), .OPC_W(OPC_W), .ROB_W(ROB_W),
    .NUM_ENTRIES(NUM_ENTRIES), .ENT_IDX_W(ENT_IDX_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_match(cfg_match), .cfg_mask(cfg_mask),
    .fu_valid(fu_valid), .fu_opcode(fu_opcode), .fu_rob_idx(fu_rob_idx),
    .fu_taint(fu_taint), .flush_valid(flush_valid), .flush_start(flush_start),
    .flush_end(flush_end), .fu_inhibit(fu_inhibit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [NUM_FU-1:0] exp);
    n_checks++;
    if (fu_inhibit !== exp) begin
      n_fail++;
      $display("FAIL %s: fu_inhibit actual %b expected %b", req, fu_inhibit, exp);
    end
  endtask

  task automatic set_fu(input int u, input logic v, input logic [OPC_W-1:0] opc,
                        input logic [ROB_W-1:0] idx, input logic t);
    fu_valid[u]                 = v;
    fu_opcode[u*OPC_W +: OPC_W] = opc;
    fu_rob_idx[u*ROB_W +: ROB_W] = idx;
    fu_taint[u]                 = t;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic write_entry(input int k, input logic en, input logic [OPC_W-1:0] m,
                             input logic [OPC_W-1:0] mk);
    cfg_we = 1'b1; cfg_idx = ENT_IDX_W'(k); cfg_en = en; cfg_match = m; cfg_mask = mk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    set_fu(0, 1, 7'h03, 4'd1, 1);
    set_fu(1, 1, 7'h63, 4'd2, 1);
    #1 check("R1 reset table empty", 3'b000);
  endtask

  task automatic t_program();
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_en = 1'b1; cfg_match = 7'h03; cfg_mask = 7'h7F;
    #1 check("R9 write not yet visible", 3'b000);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check("R9 write visible next cycle R3", 3'b001);
    write_entry(1, 1, 7'h60, 7'h70);
    #1 check("R2 masked group hit", 3'b011);
  endtask

  task automatic t_mask();
    set_fu(0, 1, 7'h6F, 4'd1, 1);
    set_fu(1, 1, 7'h13, 4'd2, 1);
    #1 check("R2 group edge hit and miss", 3'b001);
    set_fu(0, 1, 7'h02, 4'd1, 1);
    #1 check("R2 exact entry miss by one bit R4", 3'b000);
  endtask

  task automatic t_untainted_release();
    set_fu(0, 1, 7'h03, 4'd1, 0);
    #1 check("R4 untainted transmitter passes", 3'b000);
    settle();
    set_fu(0, 1, 7'h03, 4'd1, 1);
    #1 check("R3 tainted transmitter held", 3'b001);
    settle();
    #1 check("R3 hold continues", 3'b001);
    fu_taint[0] = 1'b0;
    #1 check("R5 release on taint clear", 3'b000);
    settle();
  endtask

  task automatic t_selective();
    set_fu(0, 1, 7'h03, 4'd1, 1);
    set_fu(1, 1, 7'h33, 4'd2, 1);
    set_fu(2, 1, 7'h63, 4'd3, 0);
    #1 check("R6 only unit0 blocked", 3'b001);
    set_fu(2, 1, 7'h63, 4'd3, 1);
    set_fu(0, 1, 7'h03, 4'd1, 0);
    #1 check("R6 only unit2 blocked", 3'b100);
    set_fu(2, 0, 7'h63, 4'd3, 1);
    #1 check("R10 invalid slot free", 3'b000);
    settle();
  endtask

  task automatic t_flush();
    set_fu(0, 1, 7'h03, 4'd5, 1);
    set_fu(1, 1, 7'h63, 4'd9, 1);
    set_fu(2, 0, 7'h00, 4'd0, 0);
    #1 check("R3 both held before flush", 3'b011);
    flush_valid = 1'b1; flush_start = 4'd3; flush_end = 4'd6;
    #1 check("R7 covered drops R8 uncovered stays", 3'b010);
    settle();
    flush_valid = 1'b0;
    #1 check("R7 squashed stays released", 3'b010);
    settle();
    #1 check("R7 still released", 3'b010);
    set_fu(0, 1, 7'h03, 4'd7, 1);
    #1 check("R7 new index blocks again", 3'b011);
    settle();
    set_fu(0, 1, 7'h03, 4'd1, 1);
    flush_valid = 1'b1; flush_start = 4'd14; flush_end = 4'd2;
    #1 check("R7 wrap cover, R8 wrap miss", 3'b010);
    settle();
    flush_valid = 1'b0;
    set_fu(0, 0, 7'h03, 4'd1, 1);
    settle();
    set_fu(0, 1, 7'h03, 4'd1, 1);
    #1 check("R7 valid gap ends squash", 3'b011);
    settle();
  endtask

  task automatic t_disable();
    write_entry(0, 0, 7'h03, 7'h7F);
    #1 check("R9 disabled entry no match", 3'b010);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0;
    cfg_match = '0; cfg_mask = '0; fu_valid = '0; fu_opcode = '0;
    fu_rob_idx = '0; fu_taint = '0; flush_valid = 1'b0;
    flush_start = '0; flush_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_program();
    t_mask();
    t_untainted_release();
    t_selective();
    t_flush();
    t_disable();
    settle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule